// File: doc/BRIEF.md
# Exception Entry Controller

This block decides, one clock at a time, whether a small 32-bit RISC core must enter an exception, and if so computes everything the core has to write back in that cycle. Pending causes arrive as a request vector with one bit per cause code. An external interrupt request is masked by the global interrupt-enable bit. When several causes are pending, the lowest code is taken. The winning cause falls into one of two classes. A normal exception saves the current program counter in the exception-address link register. A debug exception saves it in the breakpoint-address link register. Each class has its own saved-enable bit.

The redirected program counter is a base register plus the cause code times 32. Debug causes always use the debug base. Normal causes use the exception base, unless the remap control input is set, in which case they move onto the debug base. All results are registered and appear together with a one-cycle redirect strobe. The core applies the link write, the new enable bits and the new program counter when the strobe is high.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output becomes zero after that edge.
- R2: A normal cause (codes 2 instruction bus error, 4 data bus error, 5 divide by zero, 6 interrupt, 7 system call) produces `ea_we_o`=1, `ba_we_o`=0 and `link_o` = the sampled `pc_i`. `ie_o` gets bit 1 = old `ie_i[0]`, bit 2 = old `ie_i[2]` and bit 0 = 0.
- R3: A debug cause (code 1 breakpoint, code 3 watchpoint) produces `ba_we_o`=1, `ea_we_o`=0 and `link_o` = the sampled `pc_i`. `ie_o` gets bit 2 = old `ie_i[0]`, bit 1 = old `ie_i[1]` and bit 0 = 0.
- R4: `redir_pc_o` has bits 31:8 taken from the selected base, bits 7:5 equal to the cause code and bits 4:0 equal to zero. Bits 7:0 of the base inputs are ignored, so the result never carries into the base field.
- R5: A debug cause always uses `deba_i`. A normal cause uses `eba_i` when `remap_i`=0 and `deba_i` when `remap_i`=1.
- R6: Request bit 6 (interrupt) is taken only while `ie_i[0]`=1. When it is masked, any other pending cause is still served.
- R7: When several requests are pending, the lowest set cause code wins, and `cause_o` reports it.
- R8: Results appear one cycle after the requests are sampled. `redir_o` is high for a single cycle. Requests present during the cycle in which `redir_o` is high are ignored, so a request held high produces a strobe every second cycle.
- R9: Request bit 0 (reset code) has no effect.
- R10: With no effective request, `redir_o`, `ea_we_o` and `ba_we_o` are low after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req_i | input | 8 | Pending request per cause code (bit index = code) |
| pc_i | input | 32 | Program counter of the instruction being interrupted |
| ie_i | input | 3 | Enable register: bit 0 global, bit 1 normal-saved, bit 2 debug-saved |
| eba_i | input | 32 | Exception base |
| deba_i | input | 32 | Debug exception base |
| remap_i | input | 1 | Moves normal exceptions onto the debug base |
| redir_o | output | 1 | One-cycle redirect strobe |
| redir_pc_o | output | 32 | New program counter |
| cause_o | output | 3 | Cause code taken |
| ea_we_o | output | 1 | Write `link_o` to the exception-address register |
| ba_we_o | output | 1 | Write `link_o` to the breakpoint-address register |
| link_o | output | 32 | Return address to save |
| ie_o | output | 3 | Updated enable register value |

## Verification
Every result is due exactly one rising edge after the requests, program counter, enable bits and bases are sampled. The bench therefore drives all inputs on a falling edge, waits for the next rising edge plus a small delay, and only then compares the outputs. The bench's reference model carries its own expected strobe forward one step, so the cycle in which requests are ignored after a strobe is predicted rather than read from the design. Link, vector, cause and enable values are compared only in cycles where a strobe is expected. In all other cycles the write enables must be low.

// File: rtl/exc_entry_pkg.sv
// Shared constants and types for the exception entry controller.
// Assumes cause codes index the request vector directly.
package exc_entry_pkg;
    localparam int unsigned NUM_CAUSES = 8;
    localparam int unsigned CAUSE_W    = $clog2(NUM_CAUSES);
    localparam int unsigned VEC_SHIFT  = 5;                   // 32-byte vector spacing
    localparam int unsigned BASE_LSB   = CAUSE_W + VEC_SHIFT; // low base bits forced to zero

    localparam int unsigned CAUSE_RST  = 0;
    localparam int unsigned CAUSE_IRQ  = 6;

    // Causes of the debug class: breakpoint (1) and watchpoint (3)
    localparam logic [NUM_CAUSES-1:0] DEBUG_CLASS = 8'b0000_1010;

    // Enable register bit positions
    localparam int unsigned IE_GLB   = 0;
    localparam int unsigned IE_SAV_N = 1;
    localparam int unsigned IE_SAV_D = 2;
    localparam int unsigned IE_W     = 3;

    typedef struct packed {
        logic               hit;
        logic               dbg;
        logic [CAUSE_W-1:0] cause;
    } exc_pick_t;
endpackage

// File: rtl/exc_cause_pick.sv
// Masks the request vector and picks the lowest pending cause.
// Assumes blank_i is high in the cycle a redirect is being presented.
module exc_cause_pick
    import exc_entry_pkg::*;
(
    input  logic [NUM_CAUSES-1:0] req_i,
    input  logic                  glb_ie_i,
    input  logic                  blank_i,
    output exc_pick_t             pick_o
);
    logic [NUM_CAUSES-1:0] gated;
    logic [NUM_CAUSES:0]   seen;
    logic [NUM_CAUSES-1:0] first;

    // Remove the reset code, the masked interrupt and everything while blanked
    always_comb begin
        gated            = req_i;
        gated[CAUSE_RST] = 1'b0;
        gated[CAUSE_IRQ] = req_i[CAUSE_IRQ] & glb_ie_i;
        if (blank_i) gated = '0;
    end

    assign seen[0] = 1'b0;
    for (genvar g = 0; g < NUM_CAUSES; g++) begin : g_chain
        assign seen[g+1] = seen[g] | gated[g];
        assign first[g]  = gated[g] & ~seen[g];
    end

    // Encode the single winning bit into a code and its class
    always_comb begin
        logic [CAUSE_W-1:0] c;
        c = '0;
        for (int i = 0; i < NUM_CAUSES; i++) begin
            c = c | (first[i] ? CAUSE_W'(i) : '0);
        end
        pick_o.hit   = seen[NUM_CAUSES];
        pick_o.dbg   = |(first & DEBUG_CLASS);
        pick_o.cause = c;
    end
endmodule

// File: rtl/exc_vector_gen.sv
// Builds the vector address from the selected base and the cause code.
// Assumes base bits below BASE_LSB are don't-care; they are replaced.
module exc_vector_gen
    import exc_entry_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] eba_i,
    input  logic [ADDR_W-1:0] deba_i,
    input  logic              remap_i,
    input  exc_pick_t         pick_i,
    output logic [ADDR_W-1:0] vec_o
);
    logic [ADDR_W-1:0] base;

    // Base choice: debug class or remap selects the debug base
    always_comb base = (pick_i.dbg || remap_i) ? deba_i : eba_i;

    // Concatenation in place of an adder: no carry path into the base
    always_comb vec_o = {base[ADDR_W-1:BASE_LSB], pick_i.cause, {VEC_SHIFT{1'b0}}};
endmodule

// File: rtl/exc_enable_upd.sv
// Computes the enable register value after entry for either class.
// Assumes it is only consumed when an entry is taken.
module exc_enable_upd
    import exc_entry_pkg::*;
(
    input  logic [IE_W-1:0] ie_i,
    input  logic            dbg_i,
    output logic [IE_W-1:0] ie_o
);
    // Save global enable into the class's saved bit and clear it
    always_comb begin
        ie_o = ie_i;
        if (dbg_i) ie_o[IE_SAV_D] = ie_i[IE_GLB];
        else       ie_o[IE_SAV_N] = ie_i[IE_GLB];
        ie_o[IE_GLB] = 1'b0;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception entry controller top: registers the redirect, link and enable
// results one cycle after requests are sampled. Assumes the core applies
// them only while redir_o is high.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CAUSES-1:0] exc_req_i,
    input  logic [ADDR_W-1:0]     pc_i,
    input  logic [IE_W-1:0]       ie_i,
    input  logic [ADDR_W-1:0]     eba_i,
    input  logic [ADDR_W-1:0]     deba_i,
    input  logic                  remap_i,
    output logic                  redir_o,
    output logic [ADDR_W-1:0]     redir_pc_o,
    output logic [CAUSE_W-1:0]    cause_o,
    output logic                  ea_we_o,
    output logic                  ba_we_o,
    output logic [ADDR_W-1:0]     link_o,
    output logic [IE_W-1:0]       ie_o
);
    exc_pick_t         pick;
    logic [ADDR_W-1:0] vec;
    logic [IE_W-1:0]   ie_next;

    exc_cause_pick u_pick (
        .req_i    (exc_req_i),
        .glb_ie_i (ie_i[IE_GLB]),
        .blank_i  (redir_o),
        .pick_o   (pick)
    );

    exc_vector_gen #(.ADDR_W(ADDR_W)) u_vec (
        .eba_i   (eba_i),
        .deba_i  (deba_i),
        .remap_i (remap_i),
        .pick_i  (pick),
        .vec_o   (vec)
    );

    exc_enable_upd u_ie (
        .ie_i  (ie_i),
        .dbg_i (pick.dbg),
        .ie_o  (ie_next)
    );

    // Strobe and link-write enables, cleared whenever no entry is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_o <= 1'b0;
            ea_we_o <= 1'b0;
            ba_we_o <= 1'b0;
        end else begin
            redir_o <= pick.hit;
            ea_we_o <= pick.hit & ~pick.dbg;
            ba_we_o <= pick.hit &  pick.dbg;
        end
    end

    // Data results, loaded on entry and held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_pc_o <= '0;
            cause_o    <= '0;
            link_o     <= '0;
            ie_o       <= '0;
        end else if (pick.hit) begin
            redir_pc_o <= vec;
            cause_o    <= pick.cause;
            link_o     <= pc_i;
            ie_o       <= ie_next;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
// Protocol checks for exc_entry_ctrl, attached by bind. Observes ports only.
module exc_entry_ctrl_chk
    import exc_entry_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_CAUSES-1:0] exc_req_i,
    input logic [ADDR_W-1:0]     pc_i,
    input logic [IE_W-1:0]       ie_i,
    input logic [ADDR_W-1:0]     eba_i,
    input logic [ADDR_W-1:0]     deba_i,
    input logic                  remap_i,
    input logic                  redir_o,
    input logic [ADDR_W-1:0]     redir_pc_o,
    input logic [CAUSE_W-1:0]    cause_o,
    input logic                  ea_we_o,
    input logic                  ba_we_o,
    input logic [ADDR_W-1:0]     link_o,
    input logic [IE_W-1:0]       ie_o
);
    // R8: strobe never lasts two cycles
    a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |=> !redir_o);

    // R2/R3: exactly one link register written per entry
    a_r2_one_link: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> ($countones({ea_we_o, ba_we_o}) == 1));

    // R4: vector low bits carry the cause and nothing else
    a_r4_vec_layout: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> (redir_pc_o[BASE_LSB-1:0] == {cause_o, {VEC_SHIFT{1'b0}}}));

    // R2: saved return address is the sampled program counter
    a_r2_link_pc: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> (link_o == $past(pc_i)));

    // R3: global enable cleared on every entry
    a_r3_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> !ie_o[IE_GLB]);

    // R6: interrupt entry only with the enable set
    a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_o && cause_o == CAUSE_W'(CAUSE_IRQ)) |-> $past(ie_i[IE_GLB]));

    // R9: the reset code is never reported as taken
    a_r9_no_rst_cause: assert property (@(posedge clk) disable iff (!rst_n)
        redir_o |-> (cause_o != '0));

    // R10: no request, no strobe
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req_i[NUM_CAUSES-1:1] == '0) |=> !redir_o);
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/exc_entry_ctrl_test.sv
// Self-checking bench: directed corners plus seeded random stimulus,
// compared with a reference model built from the requirements.
module exc_entry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  exc_req_i = '0;
    logic [31:0] pc_i = '0, eba_i = '0, deba_i = '0;
    logic [2:0]  ie_i = '0;
    logic        remap_i = 1'b0;
    logic        redir_o, ea_we_o, ba_we_o;
    logic [31:0] redir_pc_o, link_o;
    logic [2:0]  cause_o, ie_o;

    int checks = 0;
    int errors = 0;
    logic exp_prev = 1'b0;

    always #5 clk = ~clk;

    exc_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .exc_req_i(exc_req_i), .pc_i(pc_i),
        .ie_i(ie_i), .eba_i(eba_i), .deba_i(deba_i), .remap_i(remap_i),
        .redir_o(redir_o), .redir_pc_o(redir_pc_o), .cause_o(cause_o),
        .ea_we_o(ea_we_o), .ba_we_o(ba_we_o), .link_o(link_o), .ie_o(ie_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference: lowest effective code, or none
    function automatic int pick_cause(logic [7:0] req, logic glb, logic blank);
        logic [7:0] g;
        g = req;
        g[0] = 1'b0;
        if (!glb) g[6] = 1'b0;
        if (blank) return -1;
        for (int i = 0; i < 8; i++) if (g[i]) return i;
        return -1;
    endfunction

    // Drive on falling edge, sample one rising edge later
    task automatic step(input logic [7:0] req, input logic [2:0] ie,
                        input logic remap, input string tag);
        int c;
        logic dbg;
        logic [31:0] base, pc_s;
        logic [2:0] ie_exp;
        @(negedge clk);
        exc_req_i = req; ie_i = ie; remap_i = remap;
        pc_i = $urandom; eba_i = $urandom; deba_i = $urandom;
        pc_s = pc_i;
        c = pick_cause(req, ie[0], exp_prev);
        dbg = (c == 1) || (c == 3);
        base = (dbg || remap) ? deba_i : eba_i;
        ie_exp = ie;
        if (dbg) ie_exp[2] = ie[0]; else ie_exp[1] = ie[0];
        ie_exp[0] = 1'b0;
        @(posedge clk);
        #1;
        chk(tag, "redir", {31'b0, redir_o}, {31'b0, c >= 0});
        if (c >= 0) begin
            chk(dbg ? "R3" : "R2", "ea_we", {31'b0, ea_we_o}, {31'b0, !dbg});
            chk(dbg ? "R3" : "R2", "ba_we", {31'b0, ba_we_o}, {31'b0, dbg});
            chk(dbg ? "R3" : "R2", "link", link_o, pc_s);
            chk(dbg ? "R3" : "R2", "ie", {29'b0, ie_o}, {29'b0, ie_exp});
            chk("R4", "vector", redir_pc_o, {base[31:8], c[2:0], 5'b0});
            chk("R7", "cause", {29'b0, cause_o}, {29'b0, c[2:0]});
        end else begin
            chk("R10", "ea_we idle", {31'b0, ea_we_o}, 32'd0);
            chk("R10", "ba_we idle", {31'b0, ba_we_o}, 32'd0);
        end
        exp_prev = (c >= 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "redir", {31'b0, redir_o}, 32'd0);
        chk("R1", "pc", redir_pc_o, 32'd0);
        chk("R1", "link", link_o, 32'd0);
        chk("R1", "we", {30'b0, ea_we_o, ba_we_o}, 32'd0);
        chk("R1", "ie", {29'b0, ie_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 and R5: normal cause with and without remap
        step(8'h20, 3'b001, 1'b0, "R2");
        step(8'h00, 3'b000, 1'b0, "R10");
        step(8'h20, 3'b101, 1'b1, "R5");
        step(8'h00, 3'b000, 1'b0, "R10");
        // R3 and R5: debug cause ignores remap
        step(8'h08, 3'b011, 1'b0, "R3");
        step(8'h00, 3'b000, 1'b0, "R10");
        step(8'h02, 3'b001, 1'b1, "R5");
        step(8'h00, 3'b000, 1'b0, "R10");
        // R6: masked interrupt alone, then with system call pending
        step(8'h40, 3'b110, 1'b0, "R6");
        step(8'hC0, 3'b110, 1'b0, "R6");
        step(8'h00, 3'b000, 1'b0, "R10");
        step(8'h40, 3'b001, 1'b0, "R6");
        step(8'h00, 3'b000, 1'b0, "R10");
        // R7: several pending, lowest wins
        step(8'hFE, 3'b001, 1'b0, "R7");
        step(8'h00, 3'b000, 1'b0, "R10");
        step(8'hB0, 3'b001, 1'b0, "R7");
        step(8'h00, 3'b000, 1'b0, "R10");
        // R9: reset code alone has no effect
        step(8'h01, 3'b001, 1'b0, "R9");
        // R8: held request strobes every second cycle
        for (int k = 0; k < 4; k++) step(8'h10, 3'b001, 1'b0, "R8");
        step(8'h00, 3'b000, 1'b0, "R10");

        // Random mix, sparse requests
        for (int n = 0; n < 600; n++) begin
            logic [7:0] r;
            r = 8'($urandom) & 8'($urandom) & 8'($urandom);
            step(r, 3'($urandom), 1'($urandom), "R8");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule